// File: doc/BRIEF.md
# Partitioned-Input Built-In Self-Test Pattern Generator

This block produces stimulus vectors for a combinational logic cone during built-in self-test. The vector is split into two fixed slices. The upper slice is the constrained slice. A loadable register drives it, and that register either takes a stored constraint value or steps as an LFSR. The lower slice is the free slice. A re-seedable LFSR drives it. A small constraint table, fixed at elaboration, holds one value for the constrained slice per entry.

A run starts with `start` and has two phases. In phase one, the constrained slice is held at each table entry in turn. For each entry, the free slice is restarted from its seed and emits exactly `V1` patterns. A comparator detects the last of those patterns by matching the free slice against its precomputed state after `V1-1` steps, so no cycle counter is needed. An address register then moves to the next entry. After the last entry, the generator raises its end-of-constraints flag and enters phase two. In phase two, both slices step together for `V2` patterns, and a second comparator on the whole vector detects the final pattern. The generator then raises `done` and holds the last vector until the next `start`.

The controller has four states: `ST_IDLE`, `ST_PHASE1`, `ST_PHASE2` and `ST_DONE`. Its transitions are:
- IDLE→PHASE1 (start)
- PHASE1→PHASE1 (next constraint, when the free-slice comparator fires and entries remain)
- PHASE1→PHASE2 (last constraint finished)
- PHASE2→DONE (whole-vector comparator fires)
- DONE→PHASE1 (start again)

Top module: `pib_pattern_gen`

## Requirements
- R1: Reset has the following effects:
  - `pattern` shows zeros in its upper `K_CON` bits and `FREE_SEED` in its lower `N_IN-K_CON` bits.
  - `pat_valid`, `end_flag` and `done` are low.
- R2: A `start` sampled in the idle or done state makes the next cycle show the first pattern. That pattern has `pat_valid` high, the upper slice equal to table entry 0, and the lower slice equal to `FREE_SEED`. Table entry i sits at bits [i*K_CON +: K_CON] of `CON_TABLE`.
- R3: In phase one, the upper slice holds its entry. From each pattern to the next, the lower slice q steps as {q[W-2:0], ^(q & FREE_TAPS)}.
- R4: Each table entry is shown for exactly `V1` consecutive patterns. The next pattern carries the next entry and `FREE_SEED`.
- R5: After the last entry, both slices step together from the last phase-one vector. The upper slice steps by the same left-shift rule with `CON_TAPS`, and `end_flag` is high.
- R6: Phase two emits exactly `V2` patterns. Over the whole run, `pat_valid` is high for exactly `N_CON*V1+V2` consecutive cycles.
- R7: After the last pattern, `done` is high and `pat_valid` is low. `pattern` then holds the last emitted vector until `start`.
- R8: `start` asserted while patterns are being emitted has no effect on the sequence.
- R9: A `start` while `done` is high replays the identical sequence from its first pattern.
- R10: `end_flag` is low throughout phase one. It stays high through all of phase two and the done state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (used only when idle or done) |
| pattern | output | N_IN | Test vector; upper K_CON bits constrained, lower bits free |
| pat_valid | output | 1 | High on every cycle that carries a pattern of the run |
| end_flag | output | 1 | High once the constraint table is exhausted |
| done | output | 1 | High after the final pattern, until the next start |

## Verification
The assertions check the following on every cycle:
- the free slice restarts at the seed on each run start;
- the free slice advances by the LFSR rule between patterns;
- the constrained slice holds between re-seeds;
- the end-of-constraints flag never drops mid-run;
- `done` and `pat_valid` are never high together;
- the vector is frozen while done;
- the run length is exactly `N_CON*V1+V2` patterns.

The scenario tests are needed for everything that a single cycle cannot show:
- which table entry appears in which stretch;
- that the per-entry length is exactly `V1`;
- the vector values in phase two;
- that a start pulse in the middle of a run is ignored;
- that a restart replays the same sequence bit for bit.

// File: rtl/pib_pkg.sv
package pib_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PHASE1 = 2'd1,
        ST_PHASE2 = 2'd2,
        ST_DONE   = 2'd3
    } pib_state_e;

    typedef struct packed {
        logic con_load;
        logic con_shift;
        logic fr_reseed;
        logic fr_shift;
        logic addr_clr;
        logic addr_inc;
    } pib_ctl_t;

endpackage

// File: rtl/pib_con_rom.sv
module pib_con_rom #(
    parameter int K  = 6,
    parameter int NC = 4,
    parameter int AW = 2,
    parameter logic [NC*K-1:0] TABLE = '0
) (
    input  logic [AW-1:0] rd_addr,
    output logic [K-1:0]  rd_data
);
    logic [K-1:0] entry [NC];

    for (genvar i = 0; i < NC; i++) begin : g_entry
        assign entry[i] = TABLE[i*K +: K];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NC; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = entry[i];
            end
        end
    end
endmodule

// File: rtl/pib_con_lfsr.sv
module pib_con_lfsr #(
    parameter int W = 6,
    parameter logic [W-1:0] TAPS = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    logic         fb;
    logic [W-1:0] d;

    assign fb = ^(q & TAPS);

    // Per-stage selector: stored constraint bit, previous stage, or hold.
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign d[i] = load ? load_val[i] : (shift ? fb : q[i]);
        end else begin : g_body
            assign d[i] = load ? load_val[i] : (shift ? q[i-1] : q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pib_free_lfsr.sv
module pib_free_lfsr #(
    parameter int W = 10,
    parameter logic [W-1:0] TAPS = '1,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reseed,
    input  logic         shift,
    output logic [W-1:0] q
);
    logic         fb;
    logic [W-1:0] d;

    assign fb = ^(q & TAPS);

    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign d[i] = reseed ? SEED[i] : (shift ? fb : q[i]);
        end else begin : g_body
            assign d[i] = reseed ? SEED[i] : (shift ? q[i-1] : q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pib_ctrl.sv
module pib_ctrl
    import pib_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     hit_v1,
    input  logic     hit_v2,
    input  logic     at_last,
    output pib_ctl_t ctl,
    output logic     pat_valid,
    output logic     end_flag,
    output logic     done
);
    pib_state_e state_q;
    pib_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = ST_PHASE1;
            end
            ST_PHASE1: begin
                if (hit_v1 && at_last) state_d = ST_PHASE2;
            end
            ST_PHASE2: begin
                if (hit_v2) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl       = '0;
        pat_valid = 1'b0;
        end_flag  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.con_load  = 1'b1;
                    ctl.fr_reseed = 1'b1;
                    ctl.addr_clr  = 1'b1;
                end
            end
            ST_PHASE1: begin
                pat_valid = 1'b1;
                if (hit_v1 && at_last) begin
                    ctl.con_shift = 1'b1;
                    ctl.fr_shift  = 1'b1;
                end else if (hit_v1) begin
                    ctl.con_load  = 1'b1;
                    ctl.fr_reseed = 1'b1;
                    ctl.addr_inc  = 1'b1;
                end else begin
                    ctl.fr_shift  = 1'b1;
                end
            end
            ST_PHASE2: begin
                pat_valid = 1'b1;
                end_flag  = 1'b1;
                if (!hit_v2) begin
                    ctl.con_shift = 1'b1;
                    ctl.fr_shift  = 1'b1;
                end
            end
            ST_DONE: begin
                end_flag = 1'b1;
                done     = 1'b1;
                if (start) begin
                    ctl.con_load  = 1'b1;
                    ctl.fr_reseed = 1'b1;
                    ctl.addr_clr  = 1'b1;
                end
            end
            default: begin
                pat_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pib_pattern_gen.sv
module pib_pattern_gen
    import pib_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int K_CON = 6,
    parameter int N_CON = 4,
    parameter int V1    = 12,
    parameter int V2    = 40,
    parameter logic [K_CON-1:0]      CON_TAPS  = 6'b110000,
    parameter logic [N_IN-K_CON-1:0] FREE_TAPS = 10'b1001000000,
    parameter logic [N_IN-K_CON-1:0] FREE_SEED = 10'b1011001110,
    parameter logic [N_CON*K_CON-1:0] CON_TABLE =
        {6'b100001, 6'b011111, 6'b110010, 6'b101101}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [N_IN-1:0] pattern,
    output logic            pat_valid,
    output logic            end_flag,
    output logic            done
);
    localparam int FW = N_IN - K_CON;
    localparam int AW = (N_CON > 1) ? $clog2(N_CON) : 1;

    function automatic logic [FW-1:0] free_step(logic [FW-1:0] s);
        return {s[FW-2:0], ^(s & FREE_TAPS)};
    endfunction

    function automatic logic [FW-1:0] free_adv(logic [FW-1:0] s, int n);
        logic [FW-1:0] r = s;
        for (int i = 0; i < n; i++) r = free_step(r);
        return r;
    endfunction

    function automatic logic [K_CON-1:0] con_step(logic [K_CON-1:0] s);
        return {s[K_CON-2:0], ^(s & CON_TAPS)};
    endfunction

    function automatic logic [K_CON-1:0] con_adv(logic [K_CON-1:0] s, int n);
        logic [K_CON-1:0] r = s;
        for (int i = 0; i < n; i++) r = con_step(r);
        return r;
    endfunction

    localparam logic [K_CON-1:0] LAST_CON   = CON_TABLE[(N_CON-1)*K_CON +: K_CON];
    localparam logic [FW-1:0]    TERM1      = free_adv(FREE_SEED, V1 - 1);
    localparam logic [K_CON-1:0] TERM2_CON  = con_adv(con_step(LAST_CON), V2 - 1);
    localparam logic [FW-1:0]    TERM2_FREE = free_adv(free_step(TERM1), V2 - 1);

    pib_ctl_t         ctl;
    logic [AW-1:0]    addr_q;
    logic [AW-1:0]    rom_addr;
    logic [K_CON-1:0] rom_data;
    logic [K_CON-1:0] con_q;
    logic [FW-1:0]    free_q;
    logic             hit_v1;
    logic             hit_v2;
    logic             at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ctl.addr_clr) begin
            addr_q <= '0;
        end else if (ctl.addr_inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign rom_addr = ctl.addr_clr ? '0 : addr_q + 1'b1;

    assign hit_v1  = (free_q == TERM1);
    assign hit_v2  = ({con_q, free_q} == {TERM2_CON, TERM2_FREE});
    assign at_last = (addr_q == AW'(N_CON - 1));

    pib_con_rom #(
        .K(K_CON), .NC(N_CON), .AW(AW), .TABLE(CON_TABLE)
    ) u_rom (
        .rd_addr (rom_addr),
        .rd_data (rom_data)
    );

    pib_con_lfsr #(
        .W(K_CON), .TAPS(CON_TAPS)
    ) u_con (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl.con_load),
        .shift    (ctl.con_shift),
        .load_val (rom_data),
        .q        (con_q)
    );

    pib_free_lfsr #(
        .W(FW), .TAPS(FREE_TAPS), .SEED(FREE_SEED)
    ) u_free (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (ctl.fr_reseed),
        .shift  (ctl.fr_shift),
        .q      (free_q)
    );

    pib_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .hit_v1    (hit_v1),
        .hit_v2    (hit_v2),
        .at_last   (at_last),
        .ctl       (ctl),
        .pat_valid (pat_valid),
        .end_flag  (end_flag),
        .done      (done)
    );

    assign pattern = {con_q, free_q};
endmodule

// File: rtl/pib_pattern_gen_chk.sv
module pib_pattern_gen_chk #(
    parameter int N_IN  = 16,
    parameter int K_CON = 6,
    parameter int N_CON = 4,
    parameter int V1    = 12,
    parameter int V2    = 40,
    parameter logic [N_IN-K_CON-1:0] FREE_TAPS = '1,
    parameter logic [N_IN-K_CON-1:0] FREE_SEED = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [N_IN-1:0] pattern,
    input logic            pat_valid,
    input logic            end_flag,
    input logic            done
);
    localparam int FW = N_IN - K_CON;
    localparam int TOTAL = N_CON * V1 + V2;

    function automatic logic [FW-1:0] nxt(logic [FW-1:0] s);
        return {s[FW-2:0], ^(s & FREE_TAPS)};
    endfunction

    logic [FW-1:0]    fr;
    logic [K_CON-1:0] cn;
    int unsigned      run_cnt;

    assign fr = pattern[FW-1:0];
    assign cn = pattern[N_IN-1:FW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (start && !pat_valid) begin
            run_cnt <= 0;
        end else if (pat_valid) begin
            run_cnt <= run_cnt + 1;
        end
    end

    assert_seed_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pat_valid) |-> fr == FREE_SEED);

    assert_con_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && !end_flag && $past(pat_valid) && fr != FREE_SEED) |-> $stable(cn));

    assert_free_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && !end_flag && $past(pat_valid) && fr != FREE_SEED) |-> fr == nxt($past(fr)));

    assert_free_step_phase2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && end_flag && $past(pat_valid)) |-> fr == nxt($past(fr)));

    assert_run_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> run_cnt == TOTAL);

    assert_done_not_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && pat_valid));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(pattern));

    assert_end_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(end_flag) && !$past(start)) |-> end_flag);

    assert_done_implies_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> end_flag);
endmodule

bind pib_pattern_gen pib_pattern_gen_chk #(
    .N_IN(N_IN), .K_CON(K_CON), .N_CON(N_CON), .V1(V1), .V2(V2),
    .FREE_TAPS(FREE_TAPS), .FREE_SEED(FREE_SEED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pattern   (pattern),
    .pat_valid (pat_valid),
    .end_flag  (end_flag),
    .done      (done)
);

// File: tb/tb_pib_pattern_gen.sv
module tb_pib_pattern_gen;
    localparam int N_IN  = 16;
    localparam int K_CON = 6;
    localparam int FW    = N_IN - K_CON;
    localparam int N_CON = 4;
    localparam int V1    = 12;
    localparam int V2    = 40;
    localparam logic [K_CON-1:0] C_TAPS = 6'b110000;
    localparam logic [FW-1:0]    F_TAPS = 10'b1001000000;
    localparam logic [FW-1:0]    F_SEED = 10'b1011001110;
    localparam logic [K_CON-1:0] TBL [N_CON] = '{6'b101101, 6'b110010, 6'b011111, 6'b100001};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N_IN-1:0] pattern;
    logic            pat_valid;
    logic            end_flag;
    logic            done;

    int n_checks = 0;
    int n_fails  = 0;
    logic [N_IN-1:0] last_pat;

    always #4 clk = ~clk;

    pib_pattern_gen #(
        .N_IN(N_IN), .K_CON(K_CON), .N_CON(N_CON), .V1(V1), .V2(V2),
        .CON_TAPS(C_TAPS), .FREE_TAPS(F_TAPS), .FREE_SEED(F_SEED),
        .CON_TABLE({TBL[3], TBL[2], TBL[1], TBL[0]})
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
        .pat_valid(pat_valid), .end_flag(end_flag), .done(done)
    );

    function automatic logic [FW-1:0] f_step(logic [FW-1:0] s);
        return {s[FW-2:0], ^(s & F_TAPS)};
    endfunction

    function automatic logic [K_CON-1:0] c_step(logic [K_CON-1:0] s);
        return {s[K_CON-2:0], ^(s & C_TAPS)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(pattern == {{K_CON{1'b0}}, F_SEED}, "R1 pattern in reset", 32'(pattern), 32'({{K_CON{1'b0}}, F_SEED}));
        check({pat_valid, end_flag, done} == 3'b000, "R1 flags in reset", 32'({pat_valid, end_flag, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pattern == {{K_CON{1'b0}}, F_SEED}, "R1 pattern after release", 32'(pattern), 32'({{K_CON{1'b0}}, F_SEED}));
        check({pat_valid, end_flag, done} == 3'b000, "R1 idle flags", 32'({pat_valid, end_flag, done}), 0);
    endtask

    // Runs one complete sequence from a start pulse and checks every pattern.
    task automatic run_sequence(input bit poke, input string tag);
        logic [K_CON-1:0] mc;
        logic [FW-1:0]    mf;
        int p = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mc = TBL[0];
        mf = F_SEED;
        check(pattern == {mc, mf}, {tag, " R2 first pattern"}, 32'(pattern), 32'({mc, mf}));
        for (int c = 0; c < N_CON; c++) begin
            for (int j = 0; j < V1; j++) begin
                check(pat_valid && !end_flag, {tag, " R10 phase1 flags"}, 32'({pat_valid, end_flag}), 32'b10);
                check(pattern == {mc, mf}, (j == 0) ? {tag, " R4 entry load"} : {tag, " R3 phase1 step"},
                      32'(pattern), 32'({mc, mf}));
                if (j == V1 - 1) begin
                    if (c == N_CON - 1) begin
                        mc = c_step(mc);
                        mf = f_step(mf);
                    end else begin
                        mc = TBL[c+1];
                        mf = F_SEED;
                    end
                end else begin
                    mf = f_step(mf);
                end
                start = poke && (p == 3 || p == V1 + 5);
                p++;
                @(negedge clk);
                start = 1'b0;
            end
        end
        for (int j = 0; j < V2; j++) begin
            check(pat_valid && end_flag && !done, {tag, " R5 phase2 flags"}, 32'({pat_valid, end_flag, done}), 32'b110);
            check(pattern == {mc, mf}, {tag, " R5 phase2 pattern"}, 32'(pattern), 32'({mc, mf}));
            last_pat = {mc, mf};
            mc = c_step(mc);
            mf = f_step(mf);
            start = poke && (j == 0 || j == V2 - 2);
            p++;
            @(negedge clk);
            start = 1'b0;
        end
        check(p == N_CON * V1 + V2 && !pat_valid, {tag, " R6 total count"}, 32'(p), 32'(N_CON * V1 + V2));
        check(done && end_flag, {tag, " R7 done raised"}, 32'({done, end_flag}), 32'b11);
        check(pattern == last_pat, {tag, " R7 last pattern held"}, 32'(pattern), 32'(last_pat));
    endtask

    task automatic t_full_run();
        run_sequence(1'b0, "full");
    endtask

    task automatic t_hold_done();
        repeat (6) @(negedge clk);
        check(done && !pat_valid, "R7 done persists", 32'({done, pat_valid}), 32'b10);
        check(pattern == last_pat, "R7 hold in done", 32'(pattern), 32'(last_pat));
        check(end_flag, "R10 end held in done", 32'(end_flag), 1);
    endtask

    task automatic t_restart();
        // Restart from done: R9 requires an identical replay.
        run_sequence(1'b0, "R9 restart");
    endtask

    task automatic t_ignore_start();
        // Start pulses in both phases must not disturb the sequence (R8).
        run_sequence(1'b1, "R8 start pulses");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_full_run();
        t_hold_done();
        t_restart();
        t_ignore_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule